// File: doc/BRIEF.md
# Streaming Grayscale Morphology Sequencer

This block takes one 8-bit grayscale frame over a valid/ready stream, stores it in an on-chip frame buffer, and runs a series of 3x3 square-window passes over it. Each pass is either a dilation (the largest value in the window) or an erosion (the smallest). A two-bit mode input picks opening, closing or morphological gradient. An iteration input sets how many passes of each operator an opening or closing runs. The processed frame then leaves on a second valid/ready stream in raster order, with a start-of-frame flag on its first pixel and an end-of-row flag on the last pixel of each row.

Iterated passes are grouped by operator. An opening of depth n runs n erosions and then n dilations, and a closing runs n dilations and then n erosions. Pairs are never interleaved. For the gradient, the block dilates the stored input into a second buffer, then erodes the untouched input. It streams out the difference between the two images pixel by pixel. Mode and depth are sampled once per frame, so both can change from one frame to the next with the same datapath.

Top module: `morph_seq`

## Requirements
- R1: A dilation pass replaces each pixel by the maximum over its 3x3 neighbourhood, with positions outside the frame taking the value of the nearest edge pixel.
- R2: An erosion pass replaces each pixel by the minimum over the same edge-replicated 3x3 neighbourhood.
- R3: Mode value 0 (opening) with depth n runs n erosion passes and then n dilation passes.
- R4: Mode value 1 (closing) with depth n runs n dilation passes and then n erosion passes.
- R5: Mode values 2 and 3 (gradient) output dilate(input) minus erode(input), one pass of each, and the depth input has no effect.
- R6: Mode and depth are sampled when the last input pixel of a frame is accepted, and a depth value of 0 acts as 1. Later changes to either input have no effect on the frame already stored.
- R7: An input pixel with in_sof high is stored as pixel 0 of the frame. Pixels accepted before it are discarded.
- R8: in_ready is high only while a frame is being loaded. It is low from the cycle after the last input pixel is accepted until the last output pixel is handed over.
- R9: busy is high from the cycle after the first input pixel is accepted until the last output handshake, and low once the block is idle.
- R10: Output pixels leave in raster order. out_sof is high only on the first pixel, and out_eol is high exactly on the pixel in the last column of each row.
- R11: While out_valid is high and out_ready is low, out_valid, out_data, out_sof and out_eol hold their values.
- R12: With P passes before the final one (2n-1 for opening or closing, 1 for gradient), out_valid first rises P*H*(W+1)+1 cycles after the edge that accepts the last input pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept an input pixel |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_data | input | 8 | Input grayscale pixel |
| mode_in | input | 2 | 0 opening, 1 closing, 2 or 3 gradient |
| iter_in | input | ITER_W | Passes per operator for opening and closing (0 treated as 1) |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink accepts the output pixel |
| out_sof | output | 1 | Output pixel is the first of the frame |
| out_eol | output | 1 | Output pixel is the last of its row |
| out_data | output | 8 | Output grayscale pixel |
| busy | output | 1 | A frame is being loaded, processed or sent |

## Verification
Each pass takes H*(W+1) cycles: one priming cycle per row plus one cycle per pixel. The first output is therefore due a fixed number of cycles after the last input edge, and that number depends only on the mode and the depth. The bench counts falling edges from that input edge and records the first cycle in which out_valid is high. It compares this count with the R12 figure. Inputs change on falling edges, and outputs are sampled 1 ns later. Each handshake is recorded at the point where it completes on the next rising edge, so output frames are collected in order even under irregular backpressure. Each collected frame is then compared with a max/min model of the same pass sequence.

// File: rtl/morph_pkg.sv
`timescale 1ns/1ps
package morph_pkg;

    typedef logic [7:0] pix_t;

    typedef enum logic {
        OP_MIN = 1'b0,
        OP_MAX = 1'b1
    } op_e;

    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

    // Decoded per-frame operation selection.
    typedef struct packed {
        logic grad;
        logic close;
    } mode_t;

    function automatic mode_t decode_mode(input logic [1:0] m);
        mode_t r;
        r.grad  = m[1];
        r.close = ~m[1] & m[0];
        return r;
    endfunction

    function automatic pix_t pick2(input op_e op, input pix_t a, input pix_t b);
        if (op == OP_MAX) return (a > b) ? a : b;
        return (a < b) ? a : b;
    endfunction

    function automatic pix_t pick3(input op_e op, input pix_t a, input pix_t b, input pix_t c);
        return pick2(op, pick2(op, a, b), c);
    endfunction

    function automatic pix_t absdiff(input pix_t a, input pix_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/morph_fbuf.sv
`timescale 1ns/1ps
module morph_fbuf
    import morph_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int NRD   = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  pix_t                    wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output pix_t [NRD-1:0]          rdata
);

    pix_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end

endmodule

// File: rtl/morph_window.sv
`timescale 1ns/1ps
module morph_window
    import morph_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  logic        prime,
    input  op_e         op,
    input  pix_t [2:0]  col,
    output pix_t        res
);

    // The square window is separable: reduce the incoming column first,
    // then combine it with the two previously reduced columns.
    pix_t col_red;
    pix_t left_q, mid_q;

    assign col_red = pick3(op, col[0], col[1], col[2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            mid_q  <= '0;
        end else if (step) begin
            if (prime) begin
                left_q <= col_red;
                mid_q  <= col_red;
            end else begin
                left_q <= mid_q;
                mid_q  <= col_red;
            end
        end
    end

    assign res = pick3(op, left_q, mid_q, col_red);

endmodule

// File: rtl/morph_ctrl.sv
`timescale 1ns/1ps
module morph_ctrl
    import morph_pkg::*;
#(
    parameter int IMG_W  = 32,
    parameter int IMG_H  = 32,
    parameter int ITER_W = 2,
    localparam int NPIX  = IMG_W * IMG_H,
    localparam int AW    = $clog2(NPIX),
    localparam int XW    = $clog2(IMG_W + 1),
    localparam int YW    = $clog2(IMG_H),
    localparam int PW    = ITER_W + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic                   in_sof,
    input  logic [1:0]             mode_in,
    input  logic [ITER_W-1:0]      iter_in,
    input  logic                   out_ready,
    output logic                   in_ready,
    output logic                   busy,
    output logic                   ing_we,
    output logic [AW-1:0]          ing_addr,
    output logic                   step,
    output logic                   prime,
    output op_e                    op,
    output logic                   src_sel,
    output logic                   grad,
    output logic [2:0][AW-1:0]     row_addr,
    output logic [AW-1:0]          pix_addr,
    output logic                   pw_we,
    output logic                   pw_sel,
    output logic                   out_valid,
    output logic                   out_sof,
    output logic                   out_eol
);

    st_e                st_q;
    logic [AW-1:0]      cnt_q;
    logic [PW-1:0]      pass_q, npass_q;
    logic [ITER_W-1:0]  iter_q;
    mode_t              mode_q;
    logic [YW-1:0]      y_q;
    logic [XW-1:0]      k_q;

    logic               accept, last_in, run, final_pass, row_end, frame_end, first_half;
    logic [AW-1:0]      wa;
    logic [ITER_W-1:0]  iter_eff;
    mode_t              mode_dec;
    logic [XW-1:0]      x_rd, x_out;
    logic [YW-1:0]      y_up, y_dn;

    function automatic logic [AW-1:0] lin(input logic [YW-1:0] yy, input logic [XW-1:0] xx);
        return AW'(yy) * AW'(IMG_W) + AW'(xx);
    endfunction

    // Frame ingest
    assign accept   = (st_q == ST_LOAD) && in_valid;
    assign wa       = in_sof ? '0 : cnt_q;
    assign last_in  = (wa == AW'(NPIX - 1));
    assign iter_eff = (iter_in == '0) ? ITER_W'(1) : iter_in;
    assign mode_dec = decode_mode(mode_in);
    assign ing_we   = accept;
    assign ing_addr = wa;
    assign in_ready = (st_q == ST_LOAD);
    assign busy     = run || (cnt_q != '0);

    // Pass schedule
    assign run        = (st_q == ST_RUN);
    assign final_pass = run && (pass_q == npass_q - PW'(1));
    assign prime      = (k_q == '0);
    assign row_end    = (k_q == XW'(IMG_W));
    assign frame_end  = (y_q == YW'(IMG_H - 1));
    assign step       = run && (prime || !final_pass || out_ready);
    assign first_half = (pass_q < PW'(iter_q));
    assign grad       = mode_q.grad;

    always_comb begin
        if (mode_q.grad) op = (pass_q == '0) ? OP_MAX : OP_MIN;
        else             op = (mode_q.close == first_half) ? OP_MAX : OP_MIN;
    end

    assign src_sel = mode_q.grad ? 1'b0 : pass_q[0];
    assign pw_sel  = ~src_sel;

    // Scan addressing with edge replication
    assign x_rd = (k_q > XW'(IMG_W - 1)) ? XW'(IMG_W - 1) : k_q;
    assign x_out = prime ? '0 : (k_q - XW'(1));
    assign y_up = (y_q == '0) ? '0 : (y_q - YW'(1));
    assign y_dn = frame_end ? y_q : (y_q + YW'(1));

    assign row_addr[0] = lin(y_up, x_rd);
    assign row_addr[1] = lin(y_q,  x_rd);
    assign row_addr[2] = lin(y_dn, x_rd);
    assign pix_addr    = lin(y_q, x_out);

    assign pw_we     = run && !final_pass && !prime;
    assign out_valid = final_pass && !prime;
    assign out_sof   = out_valid && (y_q == '0) && (k_q == XW'(1));
    assign out_eol   = out_valid && row_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_LOAD;
            cnt_q   <= '0;
            pass_q  <= '0;
            npass_q <= '0;
            iter_q  <= ITER_W'(1);
            mode_q  <= '0;
            y_q     <= '0;
            k_q     <= '0;
        end else begin
            case (st_q)
                ST_LOAD: begin
                    if (accept) begin
                        if (last_in) begin
                            st_q    <= ST_RUN;
                            cnt_q   <= '0;
                            mode_q  <= mode_dec;
                            iter_q  <= iter_eff;
                            npass_q <= mode_dec.grad ? PW'(2) : (PW'(iter_eff) << 1);
                            pass_q  <= '0;
                            y_q     <= '0;
                            k_q     <= '0;
                        end else begin
                            cnt_q <= wa + AW'(1);
                        end
                    end
                end
                ST_RUN: begin
                    if (step) begin
                        if (row_end) begin
                            k_q <= '0;
                            if (frame_end) begin
                                y_q <= '0;
                                if (final_pass) st_q <= ST_LOAD;
                                else            pass_q <= pass_q + PW'(1);
                            end else begin
                                y_q <= y_q + YW'(1);
                            end
                        end else begin
                            k_q <= k_q + XW'(1);
                        end
                    end
                end
                default: st_q <= ST_LOAD;
            endcase
        end
    end

endmodule

// File: rtl/morph_seq.sv
`timescale 1ns/1ps
module morph_seq
    import morph_pkg::*;
#(
    parameter int IMG_W  = 32,
    parameter int IMG_H  = 32,
    parameter int ITER_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sof,
    input  logic [7:0]        in_data,
    input  logic [1:0]        mode_in,
    input  logic [ITER_W-1:0] iter_in,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sof,
    output logic              out_eol,
    output logic [7:0]        out_data,
    output logic              busy
);

    localparam int NPIX = IMG_W * IMG_H;
    localparam int AW   = $clog2(NPIX);
    localparam int NBUF = 2;
    localparam int NRD  = 4;

    logic                 ing_we, step, prime, src_sel, grad, pw_we, pw_sel;
    logic [AW-1:0]        ing_addr, pix_addr;
    logic [2:0][AW-1:0]   row_addr;
    op_e                  op;
    pix_t                 res;
    pix_t [2:0]           col;

    logic [NBUF-1:0]                  buf_we;
    logic [NBUF-1:0][AW-1:0]          buf_wa;
    pix_t [NBUF-1:0]                  buf_wd;
    pix_t [NBUF-1:0][NRD-1:0]         buf_rd;
    logic [NRD-1:0][AW-1:0]           raddr;

    morph_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H), .ITER_W(ITER_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .mode_in   (mode_in),
        .iter_in   (iter_in),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .busy      (busy),
        .ing_we    (ing_we),
        .ing_addr  (ing_addr),
        .step      (step),
        .prime     (prime),
        .op        (op),
        .src_sel   (src_sel),
        .grad      (grad),
        .row_addr  (row_addr),
        .pix_addr  (pix_addr),
        .pw_we     (pw_we),
        .pw_sel    (pw_sel),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_eol   (out_eol)
    );

    assign raddr = {pix_addr, row_addr[2], row_addr[1], row_addr[0]};

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        if (b == 0) begin : g_in
            assign buf_we[b] = ing_we | (pw_we && !pw_sel);
            assign buf_wa[b] = ing_we ? ing_addr : pix_addr;
            assign buf_wd[b] = ing_we ? pix_t'(in_data) : res;
        end else begin : g_mid
            assign buf_we[b] = pw_we && pw_sel;
            assign buf_wa[b] = pix_addr;
            assign buf_wd[b] = res;
        end
        morph_fbuf #(.DEPTH(NPIX), .NRD(NRD)) u_fbuf (
            .clk   (clk),
            .we    (buf_we[b]),
            .waddr (buf_wa[b]),
            .wdata (buf_wd[b]),
            .raddr (raddr),
            .rdata (buf_rd[b])
        );
    end

    assign col = src_sel ? {buf_rd[1][2], buf_rd[1][1], buf_rd[1][0]}
                         : {buf_rd[0][2], buf_rd[0][1], buf_rd[0][0]};

    morph_window u_win (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .prime (prime),
        .op    (op),
        .col   (col),
        .res   (res)
    );

    // Gradient: dilated copy sits in buffer 1, erosion is computed live.
    assign out_data = grad ? absdiff(buf_rd[1][3], res) : res;

endmodule

// File: rtl/morph_seq_chk.sv
`timescale 1ns/1ps
module morph_seq_chk #(
    parameter int IMG_W = 32
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_sof,
    input logic       out_eol,
    input logic [7:0] out_data,
    input logic       busy
);

    localparam int CW = $clog2(IMG_W);
    logic [CW-1:0] col_q;

    always_ff @(posedge clk) begin
        if (rst) col_q <= '0;
        else if (out_valid && out_ready)
            col_q <= (col_q == CW'(IMG_W - 1)) ? '0 : col_q + CW'(1);
    end

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eol));

    assert_in_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    assert_accept_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |-> !out_valid);

    assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);

    assert_eol_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_eol == (col_q == CW'(IMG_W - 1))));

    assert_sof_R10: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid && (col_q == '0));

endmodule

bind morph_seq morph_seq_chk #(.IMG_W(IMG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sof   (out_sof),
    .out_eol   (out_eol),
    .out_data  (out_data),
    .busy      (busy)
);

// File: tb/morph_seq_test.sv
`timescale 1ns/1ps
module morph_seq_test;

    localparam int W = 12;
    localparam int H = 9;
    localparam int N = W * H;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b1;
    logic [7:0]    in_data = '0;
    logic [1:0]    mode_in = '0;
    logic [IW-1:0] iter_in = '0;
    logic          in_ready, out_valid, out_sof, out_eol, busy;
    logic [7:0]    out_data;

    int checks = 0, fails = 0;
    int src_img[N], exp_img[N], tmp_img[N], dil_img[N];
    int got[N], got_sof[N], got_eol[N];

    always #5 clk = ~clk;

    morph_seq #(.IMG_W(W), .IMG_H(H), .ITER_W(IW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
        .in_data(in_data), .mode_in(mode_in), .iter_in(iter_in), .out_valid(out_valid),
        .out_ready(out_ready), .out_sof(out_sof), .out_eol(out_eol), .out_data(out_data),
        .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic make_img(input int seed, input int kind);
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                if (kind == 0)
                    src_img[y*W+x] = (x*29 + y*71 + seed*17 + ((x*y) % 7) * 23) % 256;
                else if ((x*5 + y*3 + seed) % 11 == 0 || (x >= 6 && x < 9 && y >= 2 && y < 5))
                    src_img[y*W+x] = 200 + (x + seed) % 50;
                else
                    src_img[y*W+x] = 20 + (x + y) % 9;
            end
    endtask

    // Model of one 3x3 pass on exp_img with edge replication (R1, R2).
    task automatic ref_pass(input bit mx);
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                int v = mx ? 0 : 255;
                for (int dy = -1; dy <= 1; dy++)
                    for (int dx = -1; dx <= 1; dx++) begin
                        int yy = y + dy, xx = x + dx, p;
                        if (yy < 0) yy = 0;
                        if (yy > H-1) yy = H-1;
                        if (xx < 0) xx = 0;
                        if (xx > W-1) xx = W-1;
                        p = exp_img[yy*W+xx];
                        if (mx ? (p > v) : (p < v)) v = p;
                    end
                tmp_img[y*W+x] = v;
            end
        for (int i = 0; i < N; i++) exp_img[i] = tmp_img[i];
    endtask

    task automatic ref_frame(input int mode, input int iter);
        int n = (iter == 0) ? 1 : iter;
        for (int i = 0; i < N; i++) exp_img[i] = src_img[i];
        if (mode >= 2) begin
            ref_pass(1'b1);
            for (int i = 0; i < N; i++) begin dil_img[i] = exp_img[i]; exp_img[i] = src_img[i]; end
            ref_pass(1'b0);
            for (int i = 0; i < N; i++) exp_img[i] = dil_img[i] - exp_img[i];
        end else begin
            for (int p = 0; p < n; p++) ref_pass(mode == 1);
            for (int p = 0; p < n; p++) ref_pass(mode == 0);
        end
    endtask

    task automatic send_frame(input int pre, input int mode, input int iter, input int mode_after);
        for (int i = 0; i < pre; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_data = 8'((i * 53 + 7) % 256);
        end
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_data = 8'(src_img[i]);
            mode_in = 2'(mode); iter_in = IW'(iter);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        mode_in = 2'(mode_after); iter_in = IW'(iter + 1);
    endtask

    // Full scenario: load, collect, compare. Starts on the falling edge after the last input edge.
    task automatic run_frame(input string tag, input int mode, input int iter, input int seed,
                             input int kind, input bit bp, input int pre, input int mode_after);
        int n = (iter == 0) ? 1 : iter;
        int npre = (mode >= 2) ? 1 : 2*n - 1;
        int cyc = 0, k = 0, lat = -1, leak = 0, drop = 0, mism = 0, first = 0, mark_bad = 0;
        make_img(seed, kind);
        ref_frame(mode, iter);
        send_frame(pre, mode, iter, mode_after);
        while (k < N && cyc < 60000) begin
            out_ready = bp ? (cyc % 3 != 1) : 1'b1;
            #1;
            if (out_valid && lat < 0) lat = cyc;
            if (in_ready) leak++;
            if (!busy) drop++;
            if (out_valid && out_ready) begin
                got[k] = out_data; got_sof[k] = out_sof; got_eol[k] = out_eol; k++;
            end
            @(negedge clk);
            cyc++;
        end
        #1;
        chk(k == N, tag, "output pixel count (watchdog)", k, N);
        for (int i = 0; i < N; i++) begin
            if (got[i] != exp_img[i]) begin
                if (mism == 0) first = i;
                mism++;
            end
            if (got_sof[i] != (i == 0) || got_eol[i] != (i % W == W - 1)) mark_bad++;
        end
        chk(mism == 0, tag, $sformatf("frame pixel %0d", first), got[first], exp_img[first]);
        chk(mark_bad == 0, "R10", "sof/eol marker errors", mark_bad, 0);
        if (!bp) chk(lat == npre*H*(W+1) + 1, "R12", "first output latency", lat, npre*H*(W+1) + 1);
        chk(leak == 0, "R8", "in_ready high during processing", leak, 0);
        chk(drop == 0, "R9", "busy low during processing", drop, 0);
        chk(!busy && in_ready && !out_valid, "R9 R8", "idle after frame (busy,in_ready)",
            {busy, in_ready}, 1);
        out_ready = 1'b1;
    endtask

    task automatic t_reset;
        #1;
        chk(!out_valid, "R10", "out_valid in reset", out_valid, 0);
        chk(!busy, "R9", "busy in reset", busy, 0);
        chk(in_ready, "R8", "in_ready in reset", in_ready, 1);
    endtask

    task automatic t_busy_start;
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b1; in_data = 8'd9;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        #1;
        chk(busy, "R9", "busy after first input pixel", busy, 1);
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_busy_start();
        run_frame("R1 R2 R3 opening n=1", 0, 1, 3, 0, 1'b0, 0, 0);
        run_frame("R3 opening n=2",       0, 2, 5, 1, 1'b0, 0, 0);
        run_frame("R3 opening n=3",       0, 3, 8, 0, 1'b0, 0, 0);
        run_frame("R4 closing n=1",       1, 1, 2, 1, 1'b0, 0, 1);
        run_frame("R4 closing n=2",       1, 2, 4, 0, 1'b0, 0, 1);
        run_frame("R4 closing n=3",       1, 3, 6, 1, 1'b0, 0, 1);
        run_frame("R5 gradient mode 2",   2, 3, 7, 0, 1'b0, 0, 2);
        run_frame("R5 gradient mode 3",   3, 1, 9, 1, 1'b0, 0, 3);
        run_frame("R6 depth zero",        0, 0, 1, 1, 1'b0, 0, 0);
        run_frame("R6 late mode change",  1, 2, 11, 0, 1'b0, 0, 0);
        run_frame("R7 sof restart",       0, 2, 12, 1, 1'b0, 7, 0);
        run_frame("R11 backpressure",     1, 2, 13, 0, 1'b1, 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule